// File: doc/BRIEF.md
# Serial Display-Memory and Control-Register Loader

This block takes 16-bit words from a chip-select framed serial link and stores them either into a 240-location character memory or into nine 14-bit control registers. A single address space covers both targets. The first word of every frame carries the start address. Each later word in the same frame is written to the current address, and the address then steps up by one. The display pipeline reads the character memory through a registered read port. The control registers are always visible on a flat output bus.

The block can erase the character memory. An erase does not fill the memory with zeros. Every location gets a blank pattern instead: the character code is all ones, the three attribute bits and the blink bit are set, and the reverse bit is clear. An erase runs after every reset, and it runs again when software sets a command bit in the last control register. The erase visits one location per clock. While it runs, the busy output is high and serial data words are dropped.

The serial inputs are sampled in the system clock domain through two-stage synchronisers. The serial clock is edge-detected there.

Top module: `osd_word_loader`

## Requirements
- R1: While `rst_n` is low, every control register reads 0 and `erase_busy` is 1. After release, the memory erase runs.
- R2: A bit is taken from `sdi` on each rising edge of `sck` while `cs_n` is low, most significant bit first. Sixteen bits form one word.
- R3: The first complete word of a frame is an address word, and its bits [7:0] become the current address. It writes nothing.
- R4: Each later word in the frame writes to the current address, and the address then increments modulo 256. The same applies to addresses where the write is ignored.
- R5: Addresses 0x00–0xEF store word bits [12:0] into the character memory. `rd_data` shows location `rd_addr` one clock after `rd_addr` is presented.
- R6: Addresses 0xF0–0xF8 store word bits [13:0] into register k = address − 0xF0. Register k appears on `ctrl_regs[14k+13:14k]`.
- R7: Words addressed to 0xF9–0xFF change neither the memory nor any register.
- R8: When `cs_n` rises with fewer than 16 bits of a word received, that partial word is discarded. Words already completed in the frame keep their effect.
- R9: The blank pattern is 0x0FFF. Its layout is code in bits [7:0], attributes in [10:8], blink in 11 and reverse in 12.
- R10: Writing register 8 with bit 5 set starts an erase. Bit 5 of register 8 is never stored and always reads 0. The other bits are stored normally.
- R11: An erase writes one location per clock in ascending order, and `erase_busy` is high for exactly 240 clocks. Data words that complete while it is high are discarded, but the address still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select |
| sck | input | 1 | Serial bit clock, sampled on its rising edge |
| sdi | input | 1 | Serial data, MSB first |
| rd_addr | input | 8 | Character memory read address |
| rd_data | output | 13 | Character memory word, one clock after `rd_addr` |
| ctrl_regs | output | 126 | Nine 14-bit control registers, register k at bits 14k+13:14k |
| erase_busy | output | 1 | High while the memory erase runs |

## Verification
The assertions rely on the serial link being much slower than `clk`. Each `sck` level must last several system clocks, and `sdi` must be steady around the rising edge, so that a completed word shows up as a single-cycle pulse. The checks on the erase counter assume that the erase is only started from the idle state, which holds because command words are dropped while busy. The bench always holds each `sck` phase for at least two clocks and changes `sdi` only while `sck` is low. It drives `rd_addr` only within the memory range.

// File: rtl/owl_pkg.sv
package owl_pkg;
  parameter int WORD_W    = 16;
  parameter int DATA_W    = 14;
  parameter int MEM_W     = 13;
  parameter int ADDR_W    = 8;
  parameter int MEM_DEPTH = 240;
  parameter int REG_BASE  = 240;
  parameter int REG_COUNT = 9;
  parameter int ERASE_REG = 8;
  parameter int ERASE_BIT = 5;

  // Blank fill: code all ones, attributes and blink set, reverse clear.
  function automatic logic [MEM_W-1:0] blank_word();
    logic [MEM_W-1:0] w;
    w = '0;
    w[7:0]  = 8'hFF;
    w[10:8] = 3'b111;
    w[11]   = 1'b1;
    w[12]   = 1'b0;
    return w;
  endfunction

  function automatic logic is_mem(input logic [ADDR_W-1:0] a);
    return int'(a) < MEM_DEPTH;
  endfunction

  function automatic logic is_reg(input logic [ADDR_W-1:0] a);
    return (int'(a) >= REG_BASE) && (int'(a) < REG_BASE + REG_COUNT);
  endfunction

  function automatic int reg_index(input logic [ADDR_W-1:0] a);
    return int'(a) - REG_BASE;
  endfunction

  // Bits of register k that are actually stored.
  function automatic logic [DATA_W-1:0] reg_mask(input int k);
    logic [DATA_W-1:0] m;
    m = '1;
    if (k == ERASE_REG) m[ERASE_BIT] = 1'b0;
    return m;
  endfunction
endpackage

// File: rtl/owl_serial_rx.sv
module owl_serial_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  output logic              word_valid,
  output logic              word_first,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [1:0]        sck_m, cs_m, sdi_m;
  logic              sck_prev;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-2:0] sr;
  logic              first_pend;
  logic              sck_rise;

  assign sck_rise = sck_m[1] & ~sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_m      <= '0;
      cs_m       <= '1;
      sdi_m      <= '0;
      sck_prev   <= 1'b0;
      cnt        <= '0;
      sr         <= '0;
      first_pend <= 1'b1;
      word_valid <= 1'b0;
      word_first <= 1'b0;
      word       <= '0;
    end else begin
      sck_m      <= {sck_m[0], sck};
      cs_m       <= {cs_m[0], cs_n};
      sdi_m      <= {sdi_m[0], sdi};
      sck_prev   <= sck_m[1];
      word_valid <= 1'b0;
      if (cs_m[1]) begin
        cnt        <= '0;
        first_pend <= 1'b1;
      end else if (sck_rise) begin
        sr <= {sr[WORD_W-3:0], sdi_m[1]};
        if (cnt == LAST) begin
          word_valid <= 1'b1;
          word       <= {sr, sdi_m[1]};
          word_first <= first_pend;
          first_pend <= 1'b0;
          cnt        <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/owl_eraser.sv
module owl_eraser #(
  parameter int DEPTH  = 240,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic [ADDR_W-1:0] ptr
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b1;
      ptr  <= '0;
    end else if (busy) begin
      if (ptr == LAST) busy <= 1'b0;
      else             ptr  <= ptr + 1'b1;
    end else if (start) begin
      busy <= 1'b1;
      ptr  <= '0;
    end
  end
endmodule

// File: rtl/owl_char_mem.sv
module owl_char_mem #(
  parameter int DEPTH  = 240,
  parameter int WIDTH  = 13,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && int'(waddr) < DEPTH) mem[waddr] <= wdata;
    rdata <= (int'(raddr) < DEPTH) ? mem[raddr] : '0;
  end
endmodule

// File: rtl/osd_word_loader.sv
module osd_word_loader
  import owl_pkg::*;
#(
  parameter int P_DEPTH = MEM_DEPTH,
  parameter int P_REGS  = REG_COUNT
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_n,
  input  logic                     sck,
  input  logic                     sdi,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [MEM_W-1:0]         rd_data,
  output logic [P_REGS*DATA_W-1:0] ctrl_regs,
  output logic                     erase_busy
);
  logic              word_valid, word_first;
  logic [WORD_W-1:0] word;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] erase_ptr;
  logic              data_word;
  logic              ser_mem_we, ser_reg_we, erase_start;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [MEM_W-1:0]  mem_wdata;
  logic              unused_bits;

  owl_serial_rx #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .word_valid(word_valid), .word_first(word_first), .word(word)
  );

  assign data_word   = word_valid && !word_first;
  assign ser_mem_we  = data_word && !erase_busy && is_mem(addr_q);
  assign ser_reg_we  = data_word && !erase_busy && is_reg(addr_q);
  assign erase_start = ser_reg_we && (reg_index(addr_q) == ERASE_REG)
                       && word[ERASE_BIT];
  assign unused_bits = ^word[WORD_W-1:DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          addr_q <= '0;
    else if (word_valid) addr_q <= word_first ? word[ADDR_W-1:0]
                                              : addr_q + 1'b1;
  end

  owl_eraser #(.DEPTH(P_DEPTH), .ADDR_W(ADDR_W)) u_erase (
    .clk(clk), .rst_n(rst_n), .start(erase_start),
    .busy(erase_busy), .ptr(erase_ptr)
  );

  assign mem_we    = erase_busy || ser_mem_we;
  assign mem_waddr = erase_busy ? erase_ptr : addr_q;
  assign mem_wdata = erase_busy ? blank_word() : word[MEM_W-1:0];

  owl_char_mem #(.DEPTH(P_DEPTH), .WIDTH(MEM_W), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

  for (genvar k = 0; k < P_REGS; k++) begin : g_reg
    logic [DATA_W-1:0] r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        r_q <= '0;
      else if (ser_reg_we && reg_index(addr_q) == k)
        r_q <= word[DATA_W-1:0] & reg_mask(k);
    end
    assign ctrl_regs[k*DATA_W +: DATA_W] = r_q;
  end
endmodule

// File: rtl/owl_checker.sv
module owl_checker
  import owl_pkg::*;
#(
  parameter int DEPTH = 240,
  parameter int REGW  = 126
) (
  input logic              clk,
  input logic              rst_n,
  input logic              word_valid,
  input logic              busy,
  input logic [ADDR_W-1:0] ptr,
  input logic              ser_we,
  input logic [REGW-1:0]   regs
);
  // R1
  always @(posedge clk)
    if (!rst_n) regs_cleared_chk: assert (regs == '0);

  // R11
  no_write_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_we |-> !busy);

  // R11
  erase_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || ptr == $past(ptr) + 1'b1));

  // R11
  erase_ends_at_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ptr == ADDR_W'(DEPTH - 1));

  // R2
  word_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
endmodule

bind osd_word_loader owl_checker #(.DEPTH(P_DEPTH), .REGW(P_REGS*owl_pkg::DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .busy(erase_busy),
  .ptr(erase_ptr), .ser_we(ser_mem_we), .regs(ctrl_regs)
);

// File: tb/test_osd_word_loader.sv
module test_osd_word_loader;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs_n = 1'b1;
  logic         sck = 1'b0;
  logic         sdi = 1'b0;
  logic [7:0]   rd_addr = 8'h00;
  logic [12:0]  rd_data;
  logic [125:0] ctrl_regs;
  logic         erase_busy;
  int checks = 0;
  int fails  = 0;
  localparam logic [12:0] BLANK = 13'h0FFF;

  always #10 clk = ~clk;

  osd_word_loader i_osd_word_loader (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .rd_addr(rd_addr), .rd_data(rd_data), .ctrl_regs(ctrl_regs),
    .erase_busy(erase_busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bits(input logic [15:0] w, input int n, input int hp);
    for (int i = 0; i < n; i++) begin
      sdi = w[15-i];
      repeat (hp) @(negedge clk);
      sck = 1'b1;
      repeat (hp) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic cs_low();
    @(negedge clk); cs_n = 1'b0; repeat (3) @(negedge clk);
  endtask

  task automatic cs_high();
    repeat (6) @(negedge clk); cs_n = 1'b1; repeat (6) @(negedge clk);
  endtask

  function automatic logic [13:0] reg_of(input int k);
    return ctrl_regs[k*14 +: 14];
  endfunction

  task automatic rd(input logic [7:0] a, output logic [12:0] d);
    @(negedge clk); rd_addr = a; @(negedge clk); d = rd_data;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && erase_busy; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; repeat (3) @(negedge clk);
    chk("R1 regs zero in reset", 32'(ctrl_regs == '0), 1);
    chk("R1 busy in reset", 32'(erase_busy), 1);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_erase();
    logic [12:0] d;
    int n;
    do_reset();
    n = 0;
    while (erase_busy && n < 1000) begin @(negedge clk); n++; end
    chk("R11 erase length", n, 240);
    rd(8'h00, d); chk("R9 blank at 0x00", d, BLANK);
    rd(8'hEF, d); chk("R9 blank at 0xEF", d, BLANK);
  endtask

  task automatic t_single_and_incr();
    logic [12:0] d;
    cs_low(); bits(16'h0010, 16, 4); bits(16'h1234, 16, 4); cs_high();
    rd(8'h10, d); chk("R5 single write", d, 13'h1234);
    rd(8'h11, d); chk("R3 neighbour untouched", d, BLANK);
    cs_low(); bits(16'h0020, 16, 4); bits(16'h0AAA, 16, 3);
    bits(16'h1555, 16, 3); bits(16'h0001, 16, 2); cs_high();
    rd(8'h20, d); chk("R4 incr word0", d, 13'h0AAA);
    rd(8'h21, d); chk("R4 incr word1", d, 13'h1555);
    rd(8'h22, d); chk("R4 incr word2", d, 13'h0001);
    rd(8'h1F, d); chk("R3 before start untouched", d, BLANK);
  endtask

  task automatic t_regs();
    logic [12:0] d;
    cs_low(); bits(16'h00EF, 16, 4); bits(16'h0777, 16, 4);
    bits(16'h2ABC, 16, 4); bits(16'h3FFF, 16, 4); cs_high();
    rd(8'hEF, d); chk("R5 last memory location", d, 13'h0777);
    chk("R6 reg0 from 0xF0", reg_of(0), 14'h2ABC);
    chk("R6 reg1 from 0xF1", reg_of(1), 14'h3FFF);
    chk("R6 reg2 untouched", reg_of(2), 14'h0000);
    cs_low(); bits(16'h00F9, 16, 4); bits(16'h1111, 16, 4); cs_high();
    chk("R7 ignored address keeps regs",
        32'(ctrl_regs == {{112{1'b0}}, 14'h3FFF, 14'h2ABC}), 1);
    cs_low(); bits(16'h00FF, 16, 4); bits(16'h0123, 16, 4);
    bits(16'h0456, 16, 4); cs_high();
    rd(8'h00, d); chk("R4 address wraps to 0x00", d, 13'h0456);
  endtask

  task automatic t_partial();
    logic [12:0] d;
    cs_low(); bits(16'h0030, 16, 4); bits(16'h0999, 9, 4); cs_high();
    rd(8'h30, d); chk("R8 partial word dropped", d, BLANK);
    cs_low(); bits(16'h0031, 16, 4); bits(16'h0042, 16, 4);
    bits(16'h0043, 5, 4); cs_high();
    rd(8'h31, d); chk("R8 completed word kept", d, 13'h0042);
    rd(8'h32, d); chk("R8 trailing bits dropped", d, BLANK);
    cs_low(); bits(16'h0033, 16, 4); bits(16'h0055, 16, 4); cs_high();
    rd(8'h33, d); chk("R8 next frame aligned", d, 13'h0055);
  endtask

  task automatic t_erase_cmd();
    logic [12:0] d;
    cs_low(); bits(16'h00F8, 16, 2); bits(16'h0031, 16, 2); cs_high();
    chk("R10 erase running", 32'(erase_busy), 1);
    chk("R10 command bit not stored", reg_of(8), 14'h0011);
    cs_low(); bits(16'h0005, 16, 2); bits(16'h0123, 16, 2);
    chk("R11 still busy during frame", 32'(erase_busy), 1);
    cs_high();
    wait_idle();
    rd(8'h05, d); chk("R11 write during erase dropped", d, BLANK);
    rd(8'h10, d); chk("R10 earlier data erased", d, BLANK);
    rd(8'h20, d); chk("R10 second location erased", d, BLANK);
    chk("R10 other regs kept", reg_of(0), 14'h2ABC);
  endtask

  task automatic t_reset_again();
    logic [12:0] d;
    cs_low(); bits(16'h0040, 16, 4); bits(16'h0ABC, 16, 4); cs_high();
    rd(8'h40, d); chk("R5 write before reset", d, 13'h0ABC);
    do_reset();
    wait_idle();
    rd(8'h40, d); chk("R1 memory erased by reset", d, BLANK);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset_erase();
    t_single_and_incr();
    t_regs();
    t_partial();
    t_erase_cmd();
    t_reset_again();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule